// File: doc/BRIEF.md
# Receive FIFO with Error-Count Tracking

This block holds received bytes in a 128-entry first-in first-out store. Each stored byte carries two error flags: a parity-error bit and a framing-error bit. Two counters follow the store. One counts the held bytes that carry a parity error and the other counts the held bytes that carry a framing error. A counter goes up when a flagged byte enters and goes down when a flagged byte leaves. The counts therefore describe what is held at that moment. They are not running totals.

Both counts appear in one 16-bit read-only status word. The parity count is in the upper byte and the framing count is in the lower byte. Each field shows its count modulo 128, so a store holding 128 flagged bytes reports 0 for that field. The counts are only meaningful after the receiver's error-summary flag is set. That flag is an input here and is passed straight to an output next to the status word. The head entry is visible at all times (first-word fall-through). A synchronous clear empties the store and both counters.

Top module: `rxerr_tracker`

## Requirements
- R1: After reset, `status_word` is 0, `rx_level` is 0, `rx_empty` is 1, `rx_full` is 0 and `rx_overrun` is 0.
- R2: Bytes leave in the order they entered. `rx_head_data`, `rx_head_perr` and `rx_head_ferr` show the oldest held entry in the same cycle, with the flags it was written with.
- R3: `status_word[15:8]` is the number of held bytes whose parity flag is set. `status_word[7:0]` is the number of held bytes whose framing flag is set.
- R4: An accepted push with a flag set raises that count by one on the next clock edge. An accepted pop of an entry with that flag set lowers it by one.
- R5: When a push and a pop are both accepted in the same cycle, `rx_level` stays the same. Each count changes by the flag of the entering byte minus the flag of the leaving byte.
- R6: A count of 128 reads as 0 in its field. Bit 7 of each field is always 0.
- R7: A push while `rx_full` is 1 is dropped. `rx_overrun` is 1 for exactly the one cycle after it. The level and both counts are not changed by the dropped byte.
- R8: A pop while `rx_empty` is 1 is ignored. The level stays 0 and both counts stay 0.
- R9: `rx_clr` empties the store and zeroes both counts at the next edge. It takes priority over a push or pop in the same cycle.
- R10: `err_valid` follows the `err_summary` input in the same cycle.
- R11: `rx_level` gives the number of held bytes (0 to 128). `rx_full` is 1 exactly at 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_clr | input | 1 | Synchronous clear of the store and both counters |
| rx_push | input | 1 | Write a byte into the store |
| rx_push_data | input | 8 | Byte to write |
| rx_push_perr | input | 1 | Parity-error flag of the byte being written |
| rx_push_ferr | input | 1 | Framing-error flag of the byte being written |
| rx_pop | input | 1 | Remove the oldest held byte |
| err_summary | input | 1 | Receive error-summary flag |
| rx_head_data | output | 8 | Oldest held byte |
| rx_head_perr | output | 1 | Parity flag of the oldest held byte |
| rx_head_ferr | output | 1 | Framing flag of the oldest held byte |
| rx_level | output | 8 | Number of held bytes |
| rx_empty | output | 1 | Store holds no bytes |
| rx_full | output | 1 | Store holds 128 bytes |
| rx_overrun | output | 1 | One-cycle pulse after a dropped push |
| status_word | output | 16 | Parity count in bits 15:8, framing count in bits 7:0 |
| err_valid | output | 1 | Copy of err_summary |

## Verification
The bench pushes and pops in the same cycle while flagged entries enter and leave. A design that gave the increment priority, or forgot the decrement, would drift away from the real count. It fills the store with 128 bytes that carry both flags and expects both fields to read 0. A design that reported the raw 8-bit counter would show 0x80 there. It also pushes into a full store and pops from an empty one: a wrapping pointer or a counter going below zero would corrupt the held data or show 255. Finally it clears the store while a push is requested, which catches a clear that loses priority to the push.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
    parameter int DATA_W = 8;

    typedef struct packed {
        logic              perr;
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    localparam int N_KIND = 2;
    localparam int KIND_FER = 0;
    localparam int KIND_PER = 1;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 push_req,
    input  rxerr_pkg::rx_entry_t push_ent,
    input  logic                 pop_req,
    output rxerr_pkg::rx_entry_t head_ent,
    output logic                 push_ok,
    output logic                 pop_ok,
    output logic [CW-1:0]        level,
    output logic                 empty,
    output logic                 full,
    output logic                 overrun
);
    import rxerr_pkg::*;

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] level;
        logic          overrun;
    } st_t;

    st_t st_d, st_q;
    rx_entry_t mem_q [DEPTH];

    assign empty   = (st_q.level == '0);
    assign full    = (st_q.level == CW'(DEPTH));
    assign level   = st_q.level;
    assign overrun = st_q.overrun;
    assign head_ent = mem_q[st_q.rd_ptr];

    assign push_ok = push_req && !full && !clr;
    assign pop_ok  = pop_req && !empty && !clr;

    always_comb begin
        st_d = st_q;
        st_d.overrun = push_req && full && !clr;
        if (clr) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.level  = '0;
        end else begin
            if (push_ok) st_d.wr_ptr = st_q.wr_ptr + AW'(1);
            if (pop_ok)  st_d.rd_ptr = st_q.rd_ptr + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   st_d.level = st_q.level + CW'(1);
                2'b01:   st_d.level = st_q.level - CW'(1);
                default: st_d.level = st_q.level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr_ptr] <= push_ent;
    end

    p_level_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.level <= CW'(DEPTH));
    p_overrun_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !clr) |=> (overrun && $stable(level)));
    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && empty && !clr) |=> empty);
    p_clear_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !full));
endmodule

// File: rtl/rxq_err_cnt.sv
module rxq_err_cnt #(
    parameter int DEPTH = 128,
    parameter int FIELD_W = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               inc,
    input  logic               dec,
    output logic [CW-1:0]      count,
    output logic [FIELD_W-1:0] field
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cst_t;

    cst_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d.cnt = '0;
        end else begin
            case ({inc, dec})
                2'b10:   c_d.cnt = c_q.cnt + CW'(1);
                2'b01:   c_d.cnt = c_q.cnt - CW'(1);
                default: c_d.cnt = c_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count = c_q.cnt;
    // The field carries the count modulo DEPTH; the top count bit is not reported.
    assign field = FIELD_W'(c_q.cnt[AW-1:0]);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= CW'(DEPTH));
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && !clr) |-> (c_q.cnt != '0));
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && !clr) |=> (c_q.cnt == $past(c_q.cnt) + CW'(1)));
endmodule

// File: rtl/rxerr_tracker.sv
module rxerr_tracker #(
    parameter int DEPTH = 128,
    parameter int FIELD_W = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_clr,
    input  logic                   rx_push,
    input  logic [7:0]             rx_push_data,
    input  logic                   rx_push_perr,
    input  logic                   rx_push_ferr,
    input  logic                   rx_pop,
    input  logic                   err_summary,
    output logic [7:0]             rx_head_data,
    output logic                   rx_head_perr,
    output logic                   rx_head_ferr,
    output logic [CW-1:0]          rx_level,
    output logic                   rx_empty,
    output logic                   rx_full,
    output logic                   rx_overrun,
    output logic [2*FIELD_W-1:0]   status_word,
    output logic                   err_valid
);
    import rxerr_pkg::*;

    rx_entry_t push_ent, head_ent;
    logic push_ok, pop_ok;
    logic [N_KIND-1:0] in_flag, head_flag;
    logic [CW-1:0]      cnt   [N_KIND];
    logic [FIELD_W-1:0] fld   [N_KIND];

    assign push_ent = '{perr: rx_push_perr, ferr: rx_push_ferr, data: rx_push_data};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push_req(rx_push), .push_ent(push_ent), .pop_req(rx_pop),
        .head_ent(head_ent), .push_ok(push_ok), .pop_ok(pop_ok),
        .level(rx_level), .empty(rx_empty), .full(rx_full), .overrun(rx_overrun)
    );

    assign in_flag[KIND_PER]   = push_ent.perr;
    assign in_flag[KIND_FER]   = push_ent.ferr;
    assign head_flag[KIND_PER] = head_ent.perr;
    assign head_flag[KIND_FER] = head_ent.ferr;

    for (genvar g = 0; g < N_KIND; g++) begin : g_kind
        rxq_err_cnt #(.DEPTH(DEPTH), .FIELD_W(FIELD_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(rx_clr),
            .inc(push_ok && in_flag[g]), .dec(pop_ok && head_flag[g]),
            .count(cnt[g]), .field(fld[g])
        );
        p_cnt_le_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[g] <= rx_level);
        p_clear_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
            rx_clr |=> (cnt[g] == '0));
    end

    assign status_word  = {fld[KIND_PER], fld[KIND_FER]};
    assign rx_head_data = head_ent.data;
    assign rx_head_perr = head_ent.perr;
    assign rx_head_ferr = head_ent.ferr;
    assign err_valid    = err_summary;

    p_field_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[FIELD_W-1] && !status_word[2*FIELD_W-1]);
endmodule

// File: tb/rxerr_tracker_tb_top.sv
module rxerr_tracker_tb_top;
    logic clk = 0, rst_n = 0;
    logic rx_clr = 0, rx_push = 0, rx_pop = 0, err_summary = 0;
    logic [7:0] rx_push_data = 0;
    logic rx_push_perr = 0, rx_push_ferr = 0;
    logic [7:0] rx_head_data, rx_level;
    logic rx_head_perr, rx_head_ferr, rx_empty, rx_full, rx_overrun, err_valid;
    logic [15:0] status_word;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    rxerr_tracker dut_i (.*);

    typedef struct packed {
        logic clr, push, pop;
        logic [7:0] data;
        logic pe, fe;
        logic [7:0] head, lvl, pc, fc;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b1,1'b0,8'h11,1'b1,1'b0,8'h00,8'd1,8'd1,8'd0},
        '{1'b0,1'b1,1'b0,8'h22,1'b0,1'b1,8'h00,8'd2,8'd1,8'd1},
        '{1'b0,1'b1,1'b0,8'h33,1'b1,1'b1,8'h00,8'd3,8'd2,8'd2},
        '{1'b0,1'b1,1'b1,8'h44,1'b0,1'b0,8'h11,8'd3,8'd1,8'd2},
        '{1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,8'h22,8'd2,8'd1,8'd1},
        '{1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,8'h33,8'd1,8'd0,8'd0},
        '{1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,8'h44,8'd0,8'd0,8'd0},
        '{1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,8'h00,8'd0,8'd0,8'd0},
        '{1'b0,1'b1,1'b0,8'h55,1'b1,1'b1,8'h00,8'd1,8'd1,8'd1},
        '{1'b0,1'b1,1'b1,8'h66,1'b1,1'b0,8'h55,8'd1,8'd1,8'd0},
        '{1'b1,1'b1,1'b0,8'h77,1'b1,1'b1,8'h00,8'd0,8'd0,8'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic pu, input logic po,
                         input logic [7:0] d, input logic pe, input logic fe);
        rx_clr = c; rx_push = pu; rx_pop = po;
        rx_push_data = d; rx_push_perr = pe; rx_push_ferr = fe;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 status", status_word, 16'h0);
        chk("R1 level", rx_level, 0);
        chk("R1 empty", rx_empty, 1);
        chk("R1 full", rx_full, 0);
        chk("R1 overrun", rx_overrun, 0);
        rst_n = 1;
        @(negedge clk);

        // Table: R2 order, R3 fields, R4 steps, R5 simultaneous, R8 empty pop, R9 clear
        for (int i = 0; i < NV; i++) begin
            drive(VT[i].clr, VT[i].push, VT[i].pop, VT[i].data, VT[i].pe, VT[i].fe);
            #1;
            if (VT[i].pop && VT[i].head != 0)
                chk("R2 head order", rx_head_data, VT[i].head);
            step();
            chk("R11 level", rx_level, VT[i].lvl);
            chk("R3 R4 R5 parity field", status_word[15:8], VT[i].pc);
            chk("R3 R4 R5 framing field", status_word[7:0], VT[i].fc);
        end
        chk("R9 empty after clear", rx_empty, 1);

        // R2: head flags travel with the byte
        drive(0, 1, 0, 8'hA5, 1, 0); step();
        chk("R2 head data", rx_head_data, 8'hA5);
        chk("R2 head perr", rx_head_perr, 1);
        chk("R2 head ferr", rx_head_ferr, 0);
        drive(1, 0, 0, 0, 0, 0); step();

        // R6: fill with 128 flagged bytes
        for (int k = 0; k < 128; k++) begin
            drive(0, 1, 0, 8'(k), 1, 1); step();
        end
        chk("R11 full", rx_full, 1);
        chk("R11 level 128", rx_level, 128);
        chk("R6 count 128 reads zero", status_word, 16'h0000);

        // R7: push into full store
        drive(0, 1, 0, 8'hEE, 0, 0); step();
        chk("R7 overrun pulse", rx_overrun, 1);
        chk("R7 level kept", rx_level, 128);
        chk("R7 counts kept", status_word, 16'h0000);
        step();
        chk("R7 overrun one cycle", rx_overrun, 0);

        // pop one: 127 each, head was byte 0
        chk("R2 head after overrun", rx_head_data, 8'h00);
        drive(0, 0, 1, 0, 0, 0); step();
        chk("R6 count 127", status_word, 16'h7F7F);
        chk("R2 next head", rx_head_data, 8'h01);

        // R9: clear with pop requested
        drive(1, 0, 1, 0, 0, 0); step();
        chk("R9 clear status", status_word, 16'h0);
        chk("R9 clear level", rx_level, 0);

        // R8: pop on empty
        drive(0, 0, 1, 0, 0, 0); step();
        chk("R8 level stays", rx_level, 0);
        chk("R8 counts stay", status_word, 16'h0);
        chk("R8 empty", rx_empty, 1);

        // R10: summary mirror
        err_summary = 1; #1;
        chk("R10 valid high", err_valid, 1);
        err_summary = 0; #1;
        chk("R10 valid low", err_valid, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule